// File: doc/BRIEF.md
# Receive Descriptor Chaining Engine

This block sits between a network receive path and a ring of receive descriptors that it shares with host software. When a frame starts, it reads the control word of the current descriptor. If the host has handed that descriptor over, the engine loads the buffer address and buffer size and streams the frame's bytes into the buffer. For each byte it presents a buffer base address, a byte offset and a write strobe. When a buffer fills before the frame ends, the engine polls the next descriptor in the ring and chains the frame into it. Each buffer that has been used is handed back to the host with a single write to its control word. That write carries first-buffer and last-buffer marks and the composed error status.

Each descriptor occupies four 16-bit words starting at `ringBase + 4*index`:

| Word | Contents |
|------|----------|
| 0 | Low 16 bits of the buffer address |
| 1 | Control word: bit 15 ownership, bit 14 summary error, bit 13 framing, bit 12 overflow, bit 11 CRC, bit 10 buffer error, bit 9 first buffer, bit 8 last buffer, bits 7:0 high address byte |
| 2 | Bits 15:12 host-written ones; bits 11:0 buffer size in bytes, which must not be zero |

The ring holds `2**RING_LOG2` entries, and the index wraps to zero after the last one. The descriptor memory port completes a write at the clock edge where `memEn` and `memWe` are high. It returns read data on `memRdata` in the cycle after a read request.

Top module: `rxdc_engine`

## Requirements
- R1: At frame start, the engine reads control word 1 of the current descriptor. If bit 15 is 0, the engine accepts and discards the whole frame, performs no memory write and no payload write, and keeps the same index for the next frame.
- R2: Payload bytes are presented with `bufWe` high, with `bufAddr` = {word1[7:0], word0}, and with `bufOffset` counting 0, 1, 2, … from the start of each buffer. `bufData` equals the accepted byte.
- R3: Handing back a descriptor is exactly one write, to its word 1. The write clears bit 15 and keeps bits 7:0. Words 0 and 2 are never written.
- R4: Bit 9 is set only in the first buffer of a frame. Bit 8 is set only in the buffer that receives the final byte of a frame that was stored in full.
- R5: When the byte that fills a buffer (size = word2[11:0]) is not the last byte of the frame, the engine reads word 1 of descriptor (index+1) mod ring length. If that descriptor is owned by the engine, the frame continues in its buffer.
- R6: Bit 14 of every written status equals the OR of bits 13, 12, 11 and 10.
- R7: In the last-buffer status, bit 11 equals the frame-check-failed flag. Bit 13 equals frame-check-failed AND dribble AND NOT loopback. Both bits are 0 in any status with bit 8 clear.
- R8: A FIFO overflow pulse while bytes are being stored writes the current descriptor with bit 12 set and bit 8 clear. No byte is stored in the overflow cycle.
- R9: While chaining, bit 10 is set in the current descriptor if the next descriptor is host-owned or if an overflow arrives before the next control word is back. Bit 12 is also set only when both conditions hold.
- R10: After an overflow or buffer error, the rest of the frame is accepted and dropped. The next frame starts at the descriptor that follows the one written back, wrapping to index 0.
- R11: While reset is held, `rxReady`, `memEn` and `bufWe` are low, and the ring index restarts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringBase | input | ADDR_W | Word address of descriptor 0 |
| rxValid | input | 1 | Receive byte present |
| rxData | input | 8 | Receive byte |
| rxSof | input | 1 | Byte is the first of a frame |
| rxEof | input | 1 | Byte is the last of a frame |
| rxFcsBad | input | 1 | Frame check failed (sampled with the last byte) |
| rxDribble | input | 1 | Frame had leftover bits beyond a whole byte (sampled with the last byte) |
| rxFifoOvf | input | 1 | One-cycle FIFO overflow event |
| rxLoopback | input | 1 | Internal loopback mode |
| rxReady | output | 1 | Byte accepted at this edge when high with rxValid |
| memEn | output | 1 | Descriptor memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Descriptor memory word address |
| memWdata | output | 16 | Write data (status word) |
| memRdata | input | 16 | Read data, one cycle after the request |
| bufAddr | output | 24 | Base address of the current buffer |
| bufOffset | output | 12 | Byte offset within the current buffer |
| bufData | output | 8 | Byte to store |
| bufWe | output | 1 | Byte store strobe |

## Verification
The bench goes after the status bits whose validity depends on where the frame ended.

- A design that checks the dribble condition alone, or ignores loopback, sets the framing bit on good frames or on loopback frames.
- A design that checks chained ownership only after writing back the current buffer, or that latches the overflow at the wrong moment, reports a buffer error with a spurious or missing overflow bit.
- A design that does not wrap the index or does not step past the failed descriptor puts the next frame into the wrong buffer.
- A design that writes the whole control word back from stale state corrupts the host's high address byte.

Random frames over a small ring with random ownership and sizes drive chaining across the wrap point and onto buffers that were just returned.

// File: rtl/rxdc_pkg.sv
package rxdc_pkg;

  // Word positions inside one descriptor.
  localparam int unsigned WORD_LO   = 0;
  localparam int unsigned WORD_CTRL = 1;
  localparam int unsigned WORD_SIZE = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_CHECK, S_GETLO, S_GETSZ, S_RUN,
    S_CHAIN, S_CHECKN, S_WB, S_RDLO, S_DROP
  } rxState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadCur;   // current high address byte from read data
    logic loadNext;  // next descriptor's high address byte from read data
    logic advHdr;    // current <= next
    logic loadLo;    // low address from read data
    logic loadSize;  // buffer size from read data
    logic startBuf;  // clear offset and status for a new buffer
    logic firstBuf;  // value of first-buffer mark at startBuf
    logic incOff;    // a byte was stored
    logic setEnd;    // frame ended in this buffer
    logic setOflo;
    logic setBuff;
  } dpCtl_t;

endpackage

// File: rtl/rxdc_datapath.sv
module rxdc_datapath
  import rxdc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      ctl,
  input  logic [15:0] rdWord,
  input  logic        fcsBad,
  input  logic        dribble,
  input  logic        loopback,
  output logic [23:0] bufAddr,
  output logic [11:0] bufOffset,
  output logic        lastSlot,
  output logic [15:0] wbWord
);

  logic [7:0]  curHadr, nextHadr;
  logic [15:0] bufLo;
  logic [11:0] bufSize, offset;
  logic        stFram, stOflo, stCrc, stBuff, stStp, stEnp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curHadr  <= '0;
      nextHadr <= '0;
      bufLo    <= '0;
      bufSize  <= '0;
      offset   <= '0;
      stFram   <= 1'b0;
      stOflo   <= 1'b0;
      stCrc    <= 1'b0;
      stBuff   <= 1'b0;
      stStp    <= 1'b0;
      stEnp    <= 1'b0;
    end else begin
      if (ctl.loadCur)  curHadr  <= rdWord[7:0];
      if (ctl.advHdr)   curHadr  <= nextHadr;
      if (ctl.loadNext) nextHadr <= rdWord[7:0];
      if (ctl.loadLo)   bufLo    <= rdWord;
      if (ctl.loadSize) bufSize  <= rdWord[11:0];
      if (ctl.startBuf) begin
        offset <= '0;
        stFram <= 1'b0;
        stOflo <= 1'b0;
        stCrc  <= 1'b0;
        stBuff <= 1'b0;
        stEnp  <= 1'b0;
        stStp  <= ctl.firstBuf;
      end else begin
        if (ctl.incOff) offset <= offset + 12'd1;
        if (ctl.setEnd) begin
          stEnp  <= 1'b1;
          stCrc  <= fcsBad;
          stFram <= fcsBad & dribble & ~loopback;
        end
        if (ctl.setOflo) stOflo <= 1'b1;
        if (ctl.setBuff) stBuff <= 1'b1;
      end
    end
  end

  assign bufAddr   = {curHadr, bufLo};
  assign bufOffset = offset;
  assign lastSlot  = (offset + 12'd1) == bufSize;

  // Ownership bit returns to the host; high address byte is kept.
  assign wbWord = {1'b0, (stFram | stOflo | stCrc | stBuff), stFram, stOflo,
                   stCrc, stBuff, stStp, stEnp, curHadr};

endmodule

// File: rtl/rxdc_control.sv
module rxdc_control
  import rxdc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic              rxValid,
  input  logic              rxSof,
  input  logic              rxEof,
  input  logic              rxFifoOvf,
  input  logic              rdOwn,
  input  logic              lastSlot,
  output logic              rxReady,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              bufWe,
  output dpCtl_t            ctl
);

  rxState_t         state, nxt;
  logic [IDX_W-1:0] idx, idxNext1;
  logic             newFrame, chainOvf, afterMore, afterDrop;
  logic             wbMore, wbDrop, ovfNow;

  function automatic logic [ADDR_W-1:0] wordAddr(input logic [IDX_W-1:0] i,
                                                 input int unsigned w);
    return ringBase + ADDR_W'({i, 2'b00}) + ADDR_W'(w);
  endfunction

  assign idxNext1 = idx + 1'b1;
  assign ovfNow   = chainOvf | rxFifoOvf;

  always_comb begin
    nxt     = state;
    ctl     = '0;
    memEn   = 1'b0;
    memWe   = 1'b0;
    memAddr = ringBase;
    rxReady = 1'b0;
    bufWe   = 1'b0;
    wbMore  = 1'b0;
    wbDrop  = 1'b0;
    unique case (state)
      S_IDLE: begin
        rxReady = rxValid & ~rxSof;  // stray bytes outside a frame are dropped
        if (rxValid && rxSof) nxt = S_POLL;
      end
      S_POLL: begin
        memEn = 1'b1; memAddr = wordAddr(idx, WORD_CTRL); nxt = S_CHECK;
      end
      S_CHECK: begin
        if (rdOwn) begin
          ctl.loadCur = 1'b1;
          memEn = 1'b1; memAddr = wordAddr(idx, WORD_LO); nxt = S_GETLO;
        end else nxt = S_DROP;
      end
      S_RDLO: begin
        memEn = 1'b1; memAddr = wordAddr(idx, WORD_LO); nxt = S_GETLO;
      end
      S_GETLO: begin
        ctl.loadLo = 1'b1;
        memEn = 1'b1; memAddr = wordAddr(idx, WORD_SIZE); nxt = S_GETSZ;
      end
      S_GETSZ: begin
        ctl.loadSize = 1'b1; ctl.startBuf = 1'b1; ctl.firstBuf = newFrame;
        nxt = S_RUN;
      end
      S_RUN: begin
        rxReady = 1'b1;
        if (rxFifoOvf) begin
          ctl.setOflo = 1'b1;
          wbDrop = ~(rxValid & rxEof);
          nxt = S_WB;
        end else if (rxValid) begin
          bufWe = 1'b1; ctl.incOff = 1'b1;
          if (rxEof) begin
            ctl.setEnd = 1'b1; nxt = S_WB;
          end else if (lastSlot) nxt = S_CHAIN;
        end
      end
      S_CHAIN: begin
        memEn = 1'b1; memAddr = wordAddr(idxNext1, WORD_CTRL); nxt = S_CHECKN;
      end
      S_CHECKN: begin
        ctl.loadNext = 1'b1;
        if (!rdOwn || ovfNow) begin
          ctl.setBuff = 1'b1;
          ctl.setOflo = ~rdOwn & ovfNow;
          wbDrop = 1'b1;
        end else wbMore = 1'b1;
        nxt = S_WB;
      end
      S_WB: begin
        memEn = 1'b1; memWe = 1'b1; memAddr = wordAddr(idx, WORD_CTRL);
        ctl.advHdr = afterMore;
        nxt = afterMore ? S_RDLO : (afterDrop ? S_DROP : S_IDLE);
      end
      S_DROP: begin
        rxReady = 1'b1;
        if (rxValid && rxEof) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      idx       <= '0;
      newFrame  <= 1'b0;
      chainOvf  <= 1'b0;
      afterMore <= 1'b0;
      afterDrop <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && nxt == S_POLL) newFrame <= 1'b1;
      if (state == S_GETSZ) newFrame <= 1'b0;
      if (state == S_RUN) chainOvf <= 1'b0;
      if (state == S_CHAIN && rxFifoOvf) chainOvf <= 1'b1;
      if (nxt == S_WB && state != S_WB) begin
        afterMore <= wbMore;
        afterDrop <= wbDrop;
      end
      if (state == S_WB) idx <= idxNext1;
    end
  end

endmodule

// File: rtl/rxdc_engine.sv
module rxdc_engine
  import rxdc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RING_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxSof,
  input  logic              rxEof,
  input  logic              rxFcsBad,
  input  logic              rxDribble,
  input  logic              rxFifoOvf,
  input  logic              rxLoopback,
  output logic              rxReady,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata,
  output logic [23:0]       bufAddr,
  output logic [11:0]       bufOffset,
  output logic [7:0]        bufData,
  output logic              bufWe
);

  localparam int unsigned IDX_W = (RING_LOG2 < 1) ? 1 : RING_LOG2;

  dpCtl_t ctl;
  logic   lastSlot;

  rxdc_control #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .ringBase(ringBase),
    .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof), .rxFifoOvf(rxFifoOvf),
    .rdOwn(memRdata[15]), .lastSlot(lastSlot),
    .rxReady(rxReady), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .bufWe(bufWe), .ctl(ctl)
  );

  rxdc_datapath i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdWord(memRdata),
    .fcsBad(rxFcsBad), .dribble(rxDribble), .loopback(rxLoopback),
    .bufAddr(bufAddr), .bufOffset(bufOffset), .lastSlot(lastSlot),
    .wbWord(memWdata)
  );

  assign bufData = rxData;

endmodule

// File: rtl/rxdc_checker.sv
module rxdc_checker #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ringBase,
  input logic              rxValid,
  input logic              rxReady,
  input logic              memEn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [15:0]       memWdata,
  input logic              bufWe
);

  // R3: hand-back clears ownership
  a_r3_own_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |-> !memWdata[15]);

  // R3: only the control word of a descriptor is written
  a_r3_ctrl_word_only: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |-> (((memAddr - ringBase) & ADDR_W'(3)) == ADDR_W'(1)));

  // R3: one write per hand-back
  a_r3_single_write: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |=> !(memEn && memWe));

  // R6: summary bit follows the individual error bits
  a_r6_err_summary: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |-> (memWdata[14] == (|memWdata[13:10])));

  // R7: framing and CRC only with the last-buffer mark
  a_r7_end_only: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe && !memWdata[8]) |-> (!memWdata[13] && !memWdata[11]));

  // R8: overflow never reported with the last-buffer mark
  a_r8_oflo_not_end: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe && memWdata[12]) |-> !memWdata[8]);

  // R2: bytes are stored only when accepted, never during a memory access
  a_r2_store_accepted: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> (rxValid && rxReady && !memEn));

endmodule

bind rxdc_engine rxdc_checker #(.ADDR_W(ADDR_W)) i_rxdc_checker (
  .clk(clk), .rstN(rstN), .ringBase(ringBase), .rxValid(rxValid),
  .rxReady(rxReady), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .bufWe(bufWe)
);

// File: tb/test_rxdc_engine.sv
module test_rxdc_engine;

  localparam int AW   = 8;
  localparam int RING = 4;
  localparam logic [AW-1:0] BASE = 8'h40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0, rxSof = 1'b0, rxEof = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxFcsBad = 1'b0, rxDribble = 1'b0, rxFifoOvf = 1'b0, rxLoopback = 1'b0;
  logic        rxReady, memEn, memWe, bufWe;
  logic [AW-1:0] memAddr;
  logic [15:0] memWdata, memRdata;
  logic [23:0] bufAddr;
  logic [11:0] bufOffset;
  logic [7:0]  bufData;

  logic          hostWe = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [15:0]   hostData = '0;

  logic [15:0] mem [0:255];
  logic [7:0]  pay [0:255];
  logic [7:0]  expPay [0:255];
  bit          expSet [0:255];
  logic [15:0] expW0 [0:RING-1], expW1 [0:RING-1], expW2 [0:RING-1];
  logic [7:0]  liveHadr [0:RING-1];
  int          mIdx = 0;
  int          payWrites = 0, expWrites = 0, badAddr = 0;
  int          tests = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  rxdc_engine #(.ADDR_W(AW), .RING_LOG2(2)) i_rxdc_engine (
    .clk(clk), .rstN(rstN), .ringBase(BASE),
    .rxValid(rxValid), .rxData(rxData), .rxSof(rxSof), .rxEof(rxEof),
    .rxFcsBad(rxFcsBad), .rxDribble(rxDribble), .rxFifoOvf(rxFifoOvf),
    .rxLoopback(rxLoopback), .rxReady(rxReady),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .bufAddr(bufAddr), .bufOffset(bufOffset),
    .bufData(bufData), .bufWe(bufWe)
  );

  // Descriptor memory and payload sink models
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[memAddr] <= memWdata;
      else       memRdata <= mem[memAddr];
    end
    if (hostWe) mem[hostAddr] <= hostData;
    if (bufWe) begin
      pay[8'(bufAddr[7:0] + bufOffset[7:0])] <= bufData;
      payWrites <= payWrites + 1;
      if (bufAddr[23:16] != liveHadr[bufAddr[7:6]] || bufAddr[15:8] != 8'h00 ||
          bufAddr[5:0] != 6'h00)
        badAddr <= badAddr + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); hostWe = 1'b1; hostAddr = a; hostData = d;
    @(negedge clk); hostWe = 1'b0;
  endtask

  task automatic setDesc(input int j, input bit own, input logic [7:0] hadr, input int size);
    expW0[j] = 16'(j * 64);
    expW1[j] = {own, 7'b0, hadr};
    expW2[j] = {4'hF, 12'(size)};
    liveHadr[j] = hadr;
    hostWrite(BASE + AW'(4*j),     expW0[j]);
    hostWrite(BASE + AW'(4*j + 1), expW1[j]);
    hostWrite(BASE + AW'(4*j + 2), expW2[j]);
  endtask

  function automatic logic [7:0] byteOf(input int seed, input int i);
    return 8'(seed * 13 + i * 7 + 1);
  endfunction

  // Reference model built from the requirements.
  task automatic modelFrame(input int len, input bit fcs, input bit drb, input bit lb,
                            input int mode, input int k, input int seed);
    int d, off, n;
    bit first, nown, ovf, fram;
    d = mIdx;
    if (!expW1[d][15]) return;  // R1
    first = 1'b1; off = 0;
    for (int i = 0; i < len; i++) begin
      if (mode == 1 && i == k) begin  // R8
        expW1[d] = {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, first, 1'b0, expW1[d][7:0]};
        mIdx = (d + 1) % RING; return;
      end
      expPay[d*64 + off] = byteOf(seed, i);
      expSet[d*64 + off] = 1'b1;
      expWrites++;
      off++;
      if (i == len - 1) begin  // R7
        fram = fcs & drb & ~lb;
        expW1[d] = {1'b0, fram | fcs, fram, 1'b0, fcs, 1'b0, first, 1'b1, expW1[d][7:0]};
        mIdx = (d + 1) % RING; return;
      end
      if (off == int'(expW2[d][11:0])) begin  // R5 / R9
        n = (d + 1) % RING;
        nown = expW1[n][15];
        ovf = (mode == 2 && i == k);
        if (!nown || ovf) begin
          expW1[d] = {1'b0, 1'b1, 1'b0, (!nown && ovf), 1'b0, 1'b1, first, 1'b0, expW1[d][7:0]};
          mIdx = (d + 1) % RING; return;
        end
        expW1[d] = {1'b0, 7'b0, first, 1'b0, expW1[d][7:0]};
        d = n; first = 1'b0; off = 0;
      end
    end
  endtask

  task automatic sendFrame(input int len, input bit fcs, input bit drb, input bit lb,
                           input int mode, input int k, input int seed);
    rxFcsBad = fcs; rxDribble = drb; rxLoopback = lb;
    for (int i = 0; i < len; i++) begin
      if (mode == 1 && i == k) begin
        @(negedge clk); rxValid = 1'b0; #1;
        while (!rxReady) begin @(negedge clk); #1; end
        rxFifoOvf = 1'b1;
        @(negedge clk); rxFifoOvf = 1'b0;
      end
      @(negedge clk);
      rxValid = 1'b1; rxData = byteOf(seed, i);
      rxSof = (i == 0); rxEof = (i == len - 1);
      #1;
      while (!rxReady) begin @(negedge clk); #1; end
      @(posedge clk);
      if (mode == 2 && i == k) begin
        @(negedge clk); rxValid = 1'b0; rxFifoOvf = 1'b1;
        @(negedge clk); rxFifoOvf = 1'b0;
      end
    end
    @(negedge clk);
    rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic runFrame(input string tag, input int len, input bit fcs, input bit drb,
                          input bit lb, input int mode, input int k, input int seed);
    int bad;
    logic [15:0] a, e;
    modelFrame(len, fcs, drb, lb, mode, k, seed);
    sendFrame(len, fcs, drb, lb, mode, k, seed);
    bad = 0; a = '0; e = '0;
    for (int j = 0; j < RING; j++) begin
      if (mem[BASE + AW'(4*j)] !== expW0[j])     begin bad++; a = mem[BASE + AW'(4*j)];     e = expW0[j]; end
      if (mem[BASE + AW'(4*j + 1)] !== expW1[j]) begin bad++; a = mem[BASE + AW'(4*j + 1)]; e = expW1[j]; end
      if (mem[BASE + AW'(4*j + 2)] !== expW2[j]) begin bad++; a = mem[BASE + AW'(4*j + 2)]; e = expW2[j]; end
    end
    check({tag, " descriptors"}, 32'(a), 32'(e));
    if (bad != 0 && a === e) check({tag, " descriptors"}, 32'(bad), 32'd0);
    bad = 0;
    for (int x = 0; x < 256; x++) if (expSet[x] && pay[x] !== expPay[x]) bad++;
    check("R2 payload bytes", 32'(bad), 32'd0);
    check("R2 payload write count", 32'(payWrites), 32'(expWrites));
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int x = 0; x < 256; x++) begin expSet[x] = 1'b0; expPay[x] = '0; end
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 rxReady in reset", 32'(rxReady), 32'd0);
    check("R11 memEn in reset", 32'(memEn), 32'd0);
    check("R11 bufWe in reset", 32'(bufWe), 32'd0);
    @(negedge clk); rstN = 1'b1;
    for (int j = 0; j < RING; j++) setDesc(j, 1'b0, 8'(j), 4);

    // R1: nothing owned, frame dropped, index stays at 0
    runFrame("R1", 3, 1'b0, 1'b0, 1'b0, 0, 0, 1);
    check("R1 no payload writes", 32'(payWrites), 32'd0);

    // R4/R5: chained good frame
    setDesc(0, 1'b1, 8'hA5, 4);
    setDesc(1, 1'b1, 8'h3C, 4);
    setDesc(2, 1'b1, 8'h5E, 8);
    runFrame("R5", 6, 1'b0, 1'b0, 1'b0, 0, 0, 2);
    check("R4 first buffer status", 32'(mem[BASE + 1]), 32'h02A5);
    check("R4 last buffer status", 32'(mem[BASE + 5]), 32'h013C);

    // R7/R6: bad check with dribble
    runFrame("R7", 3, 1'b1, 1'b1, 1'b0, 0, 0, 3);
    check("R7 R6 framing and crc", 32'(mem[BASE + 9]), 32'h6B5E);

    // R7: loopback suppresses framing; R10 wrap to index 0 afterwards
    setDesc(3, 1'b1, 8'h77, 8);
    setDesc(0, 1'b1, 8'h11, 8);
    runFrame("R7 loopback", 2, 1'b1, 1'b1, 1'b1, 0, 0, 4);

    // R8: overflow while storing
    runFrame("R8", 6, 1'b0, 1'b0, 1'b0, 1, 2, 5);
    check("R8 overflow status", 32'(mem[BASE + 1]), 32'h5211);

    // R10: next frame goes to descriptor 1
    setDesc(1, 1'b1, 8'h66, 8);
    runFrame("R10", 2, 1'b0, 1'b0, 1'b0, 0, 0, 6);

    // R9: next descriptor host-owned
    setDesc(2, 1'b1, 8'h22, 2);
    runFrame("R9 not owned", 5, 1'b0, 1'b0, 1'b0, 0, 0, 7);
    check("R9 buffer error only", 32'(mem[BASE + 9]), 32'h4622);

    // R9: overflow during chain poll, next owned
    setDesc(3, 1'b1, 8'h33, 2);
    setDesc(0, 1'b1, 8'h44, 8);
    runFrame("R9 ovf owned", 4, 1'b0, 1'b0, 1'b0, 2, 1, 8);

    // R9: both conditions at once
    runFrame("R9 both", 10, 1'b0, 1'b0, 1'b0, 2, 7, 9);
    check("R9 buffer plus overflow", 32'(mem[BASE + 1]), 32'h5644);

    // Random frames
    for (int f = 0; f < 40; f++) begin
      int len, mode, k;
      for (int j = 0; j < RING; j++)
        if (!expW1[j][15] && ($urandom % 4) != 0)
          setDesc(j, 1'b1, 8'($urandom), 1 + int'($urandom % 12));
      len = 1 + int'($urandom % 30);
      mode = 0; k = 0;
      if (len > 1 && ($urandom % 8) == 0) begin
        mode = 1; k = 1 + int'($urandom % (len - 1));
      end
      runFrame("R10 random", len, ($urandom % 4) == 0, ($urandom % 3) == 0,
               ($urandom % 5) == 0, mode, k, 100 + f);
    end
    check("R2 buffer address", 32'(badAddr), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule